// File: doc/BRIEF.md
# In-Place Partially-Mapped Crossover Engine

This block recombines two travelling-salesman tours, each a permutation of `N_GENES` city indices, with partially-mapped crossover. Two cut points mark an inclusive middle window. The first child keeps the second parent's window and takes its outer genes from the first parent. The second child keeps the first parent's window and takes its outer genes from the second parent. Any outer gene that would repeat a city already in the kept window is remapped through the window until it is unique. Both tours live in flip-flop arrays. Each child is written over the other parent, so only one scratch copy is needed: it holds the second parent's genes before they are overwritten.

Software or a controlling engine loads both parents through a write port while the block is idle. It pulses `start` with the two cut points, waits for `done`, and then reads the children back through a combinational read port. Each conflict check compares a candidate gene with every window position in one cycle, using one equality comparator per chromosome position. The run time therefore depends only on the cut points and on the length of the remap chains.

Top module: `pmx_crossover`

## Requirements
- R1: After reset, gene i of both chromosome stores equals i (an identity tour), and `busy` and `done` are low.
- R2: While the block is idle, `wr_en` writes `wr_data` into position `wr_addr` of the store chosen by `wr_sel` (0 = first store / parent 1, 1 = second store / parent 2). `rd_data` shows gene `rd_addr` of the store chosen by `rd_sel` in the same cycle.
- R3: After a run, the second store holds child 1. Positions cut_lo..cut_hi keep parent 2's genes. Every other position i holds parent 1's gene i, after remapping.
- R4: After a run, the first store holds child 2. Positions cut_lo..cut_hi keep parent 1's genes. Every other position i holds parent 2's original gene i, after remapping.
- R5: Remapping for child 1: a candidate equal to parent 2's window gene at position j is replaced by parent 1's gene at j. This is repeated until the candidate matches no window gene. Child 2 uses the same rule with the parents swapped.
- R6: The window is inclusive, with 0 <= cut_lo <= cut_hi < N_GENES. With cut_lo = 0 there is no top part, and with cut_hi = N_GENES-1 there is no bottom part. A missing part is skipped and costs only its selection cycle.
- R7: With `start` sampled at clock edge 1, `done` first reads high after edge 1 + ceil(N_GENES/2) + 5 + 3·(2·outer genes) + (total remap steps). Here "outer genes" is cut_lo + (N_GENES-1-cut_hi).
- R8: `busy` is high from the edge that samples `start` until the edge that sets `done`. `done` then stays high until the next accepted `start`.
- R9: While `busy` is high, `wr_en` and `start` are ignored. A run's result does not depend on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch pulse, accepted only when idle |
| cut_lo | input | IDX_W | First position of the kept window |
| cut_hi | input | IDX_W | Last position of the kept window |
| wr_en | input | 1 | Load-port write strobe |
| wr_sel | input | 1 | Load-port store select (0 first, 1 second) |
| wr_addr | input | IDX_W | Load-port gene position |
| wr_data | input | GENE_W | Load-port gene value |
| rd_sel | input | 1 | Read-port store select |
| rd_addr | input | IDX_W | Read-port gene position |
| rd_data | output | GENE_W | Gene at the read position |
| busy | output | 1 | Crossover in progress |
| done | output | 1 | Children ready in the stores |

## Verification
The bench uses the default `N_GENES = 8`, which gives 4-bit genes, 3-bit positions and a four-cycle scratch copy. At this size, hand-picked tours reach every interesting case. One pair forces a six-step remap chain. Others cover a missing top part, a missing bottom part, a window that spans the whole tour, and a one-gene window. A reference crossover model and a latency formula in the bench are compared against every gene that is read back and against the cycle count of every run. One run also applies a load-port write and a second start pulse mid-run.

// File: rtl/pmx_pkg.sv
// pmx_pkg: shared control types for the crossover engine.
// Assumes nothing beyond IEEE 1800-2017 enums.
package pmx_pkg;

    // Controller states: idle, scratch copy, part select, gene load,
    // window probe (remap loop) and index step.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_COPY  = 3'd1,
        ST_SEL   = 3'd2,
        ST_LOAD  = 3'd3,
        ST_PROBE = 3'd4,
        ST_STEP  = 3'd5
    } pmx_state_e;

    // Part order: child 1 top, child 1 bottom, child 2 top, child 2 bottom.
    localparam logic [2:0] PART_C1_TOP = 3'd0;
    localparam logic [2:0] PART_END    = 3'd4;

endpackage

// File: rtl/pmx_chrom_mem.sv
// pmx_chrom_mem: one chromosome held in flip-flops, every gene visible at once.
// Assumes a single writer per cycle; resets to the identity tour.
module pmx_chrom_mem #(
    parameter int N_GENES = 8,
    parameter int GENE_W  = $clog2(N_GENES + 1),
    parameter int IDX_W   = $clog2(N_GENES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               waddr,
    input  logic [GENE_W-1:0]              wdata,
    output logic [N_GENES-1:0][GENE_W-1:0] genes
);

    for (genvar i = 0; i < N_GENES; i++) begin : g_cell
        // Per-position register: identity on reset, addressed write otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                genes[i] <= GENE_W'(i);
            end else if (we && (waddr == IDX_W'(i))) begin
                genes[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/pmx_match_bank.sv
// pmx_match_bank: one equality comparator per position, limited to the
// window lo..hi, giving a hit flag and the matching position in one cycle.
// Assumes the searched chromosome is a permutation while en is high.
module pmx_match_bank #(
    parameter int N_GENES = 8,
    parameter int GENE_W  = $clog2(N_GENES + 1),
    parameter int IDX_W   = $clog2(N_GENES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           en,
    input  logic [GENE_W-1:0]              key,
    input  logic [N_GENES-1:0][GENE_W-1:0] genes,
    input  logic [IDX_W-1:0]               lo,
    input  logic [IDX_W-1:0]               hi,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);

    logic [N_GENES-1:0] eq;

    for (genvar j = 0; j < N_GENES; j++) begin : g_cmp
        // Comparator j: key equals gene j and j lies inside the window.
        assign eq[j] = (genes[j] == key) && (IDX_W'(j) >= lo) && (IDX_W'(j) <= hi);
    end

    // Encode the matching position.
    always_comb begin
        hit_idx = '0;
        for (int j = 0; j < N_GENES; j++) begin
            if (eq[j]) hit_idx = IDX_W'(j);
        end
    end

    assign hit = |eq;

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $onehot0(eq)); // R5

endmodule

// File: rtl/pmx_crossover.sv
// pmx_crossover: in-place partially-mapped crossover of two stored tours.
// Child 1 overwrites the second store, child 2 overwrites the first; a
// scratch copy keeps parent 2 for child 2. Assumes both stores hold
// permutations and 0 <= cut_lo <= cut_hi < N_GENES at start.
module pmx_crossover
    import pmx_pkg::*;
#(
    parameter int N_GENES = 8,
    parameter int GENE_W  = $clog2(N_GENES + 1),
    parameter int IDX_W   = $clog2(N_GENES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  cut_lo,
    input  logic [IDX_W-1:0]  cut_hi,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [GENE_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [GENE_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);

    localparam int               HALF      = (N_GENES + 1) / 2;
    localparam logic [IDX_W-1:0] HALF_LAST = IDX_W'(HALF - 1);
    localparam logic [IDX_W-1:0] POS_LAST  = IDX_W'(N_GENES - 1);

    pmx_state_e state;
    logic [2:0]        part;
    logic [IDX_W-1:0]  k;
    logic [GENE_W-1:0] cand;
    logic [IDX_W-1:0]  lo_q, hi_q;
    logic              done_q;
    logic [N_GENES-1:0][GENE_W-1:0] tmp;
    logic [N_GENES-1:0][GENE_W-1:0] p1_genes, p2_genes;

    // Part decode: child 2 parts use the scratch source and the swapped roles.
    logic              is_c2, is_bot, part_empty;
    logic [IDX_W-1:0]  part_first, part_last;
    logic [GENE_W-1:0] src_gene;
    logic [N_GENES-1:0][GENE_W-1:0] search_genes, partner_genes;
    logic              hit, eng_we, idle;
    logic [IDX_W-1:0]  hit_idx;

    assign is_c2         = part[1];
    assign is_bot        = part[0];
    assign part_empty    = is_bot ? (hi_q == POS_LAST) : (lo_q == '0);
    assign part_first    = is_bot ? (hi_q + IDX_W'(1)) : '0;
    assign part_last     = is_bot ? POS_LAST : (lo_q - IDX_W'(1));
    assign src_gene      = is_c2 ? tmp[k] : p1_genes[k];
    assign search_genes  = is_c2 ? p1_genes : p2_genes;
    assign partner_genes = is_c2 ? p2_genes : p1_genes;
    assign idle          = (state == ST_IDLE);
    assign eng_we        = (state == ST_PROBE) && !hit;

    pmx_chrom_mem #(.N_GENES(N_GENES), .GENE_W(GENE_W), .IDX_W(IDX_W)) u_store1 (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ((idle && wr_en && !wr_sel) || (eng_we && is_c2)),
        .waddr (idle ? wr_addr : k),
        .wdata (idle ? wr_data : cand),
        .genes (p1_genes)
    );

    pmx_chrom_mem #(.N_GENES(N_GENES), .GENE_W(GENE_W), .IDX_W(IDX_W)) u_store2 (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ((idle && wr_en && wr_sel) || (eng_we && !is_c2)),
        .waddr (idle ? wr_addr : k),
        .wdata (idle ? wr_data : cand),
        .genes (p2_genes)
    );

    pmx_match_bank #(.N_GENES(N_GENES), .GENE_W(GENE_W), .IDX_W(IDX_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state == ST_PROBE),
        .key     (cand),
        .genes   (search_genes),
        .lo      (lo_q),
        .hi      (hi_q),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    // Controller: copy, then per part select, load, probe/remap, step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            part   <= PART_C1_TOP;
            k      <= '0;
            cand   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            done_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    lo_q   <= cut_lo;
                    hi_q   <= cut_hi;
                    k      <= '0;
                    part   <= PART_C1_TOP;
                    done_q <= 1'b0;
                    state  <= ST_COPY;
                end
                ST_COPY: begin
                    if (k == HALF_LAST) state <= ST_SEL;
                    else                k     <= k + IDX_W'(1);
                end
                ST_SEL: begin
                    if (part == PART_END) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (part_empty) begin
                        part <= part + 3'd1;
                    end else begin
                        k     <= part_first;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cand  <= src_gene;
                    state <= ST_PROBE;
                end
                ST_PROBE: begin
                    if (hit) cand  <= partner_genes[hit_idx];
                    else     state <= ST_STEP;
                end
                ST_STEP: begin
                    if (k == part_last) begin
                        part  <= part + 3'd1;
                        state <= ST_SEL;
                    end else begin
                        k     <= k + IDX_W'(1);
                        state <= ST_LOAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Scratch copy: top and bottom halves of parent 2 filled two per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp <= '0;
        end else if (state == ST_COPY) begin
            tmp[k]            <= p2_genes[k];
            tmp[POS_LAST - k] <= p2_genes[POS_LAST - k];
        end
    end

    assign rd_data = rd_sel ? p2_genes[rd_addr] : p1_genes[rd_addr];
    assign busy    = !idle;
    assign done    = done_q;

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> busy); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_COPY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COPY) |=> ($stable(p1_genes) && $stable(p2_genes))); // R9
    AST_OUTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> ((k < lo_q) || (k > hi_q))); // R3

endmodule

// File: tb/pmx_crossover_tb.sv
`timescale 1ns/1ps
// pmx_crossover_tb: scoreboard bench. The driver loads parents, computes
// expected children with a reference crossover, queues them, and launches
// a run; the monitor pops and compares once done is seen.
module pmx_crossover_tb;

    localparam int N     = 8;
    localparam int GW    = 4;
    localparam int IW    = 3;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = (N + 1) / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] cut_lo = '0, cut_hi = '0;
    logic          wr_en = 1'b0, wr_sel = 1'b0;
    logic [IW-1:0] wr_addr = '0;
    logic [GW-1:0] wr_data = '0;
    logic          rd_sel = 1'b0;
    logic [IW-1:0] rd_addr = '0;
    logic [GW-1:0] rd_data;
    logic          busy, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmx_crossover #(.N_GENES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cut_lo(cut_lo), .cut_hi(cut_hi),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    typedef struct {
        logic  sel;
        int    addr;
        int    val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int a1[N], a2[N], e1[N], e2[N];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Reference crossover (R3, R4, R5); returns the number of remap steps.
    function automatic int ref_pmx(input int c1, input int c2);
        int hops = 0;
        for (int i = 0; i < N; i++) begin
            if (i >= c1 && i <= c2) begin
                e1[i] = a2[i];
                e2[i] = a1[i];
            end else begin
                int g;
                bit found;
                g = a1[i]; found = 1'b1;
                while (found) begin
                    found = 1'b0;
                    for (int j = c1; j <= c2; j++)
                        if (a2[j] == g) begin g = a1[j]; found = 1'b1; hops++; break; end
                end
                e1[i] = g;
                g = a2[i]; found = 1'b1;
                while (found) begin
                    found = 1'b0;
                    for (int j = c1; j <= c2; j++)
                        if (a1[j] == g) begin g = a2[j]; found = 1'b1; hops++; break; end
                end
                e2[i] = g;
            end
        end
        return hops;
    endfunction

    // Load both parents through the write port while idle (R2).
    task automatic load_parents();
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < N; i++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_sel = s[0]; wr_addr = IW'(i);
                wr_data = GW'(s == 0 ? a1[i] : a2[i]);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < N; i++) begin
            rd_sel = 1'b0; rd_addr = IW'(i); #1;
            check(rd_data == GW'(a1[i]), "R2 load p1", int'(rd_data), a1[i]);
        end
    endtask

    // Driver: load, predict, queue, launch, time the run (R7, R8, R9).
    task automatic run_case(input int c1, input int c2, input bit disturb);
        int hops, n, expn;
        load_parents();
        hops = ref_pmx(c1, c2);
        expn = 1 + HALF + 5 + 3 * 2 * (c1 + (N - 1 - c2)) + hops;
        @(negedge clk);
        cut_lo = IW'(c1); cut_hi = IW'(c2); start = 1'b1;
        @(posedge clk); n = 1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R8 busy after start", int'(busy), 1);
        while (!done && n < 5000) begin
            wr_en   = disturb && (n == 2);
            wr_sel  = 1'b0; wr_addr = '0; wr_data = GW'(N - 1);
            start   = disturb && (n == 3);
            if (disturb && n == 3) begin cut_lo = '0; cut_hi = '0; end
            @(posedge clk); n++;
            @(negedge clk);
        end
        wr_en = 1'b0; start = 1'b0;
        check(n == expn, disturb ? "R9 latency unchanged" : "R7 latency", n, expn);
        check(busy == 1'b0, "R8 idle at done", int'(busy), 0);
        for (int i = 0; i < N; i++) begin
            exp_t it;
            it.sel = 1'b1; it.addr = i; it.val = e1[i];
            it.req = disturb ? "R9 child1" : ((i < c1 || i > c2) ? "R3/R5 child1 outer" : "R3 child1 window");
            exp_q.push_back(it);
            it.sel = 1'b0; it.val = e2[i];
            it.req = disturb ? "R9 child2" : ((i < c1 || i > c2) ? "R4/R5 child2 outer" : "R4 child2 window");
            exp_q.push_back(it);
        end
        n = 0;
        while (exp_q.size() != 0 && n < 1000) begin @(negedge clk); n++; end
        check(done == 1'b1, "R8 done held", int'(done), 1);
    endtask

    // Monitor: pop queued expectations and compare against the read port.
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                while (exp_q.size() != 0) begin
                    exp_t it;
                    it = exp_q.pop_front();
                    rd_sel = it.sel; rd_addr = IW'(it.addr);
                    #1;
                    check(rd_data == GW'(it.val), it.req, int'(rd_data), it.val);
                end
            end
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: identity stores, idle flags.
        check(busy == 1'b0 && done == 1'b0, "R1 flags", int'({busy, done}), 0);
        for (int i = 0; i < N; i++) begin
            rd_sel = 1'b0; rd_addr = IW'(i); #1;
            check(rd_data == GW'(i), "R1 store1 identity", int'(rd_data), i);
            rd_sel = 1'b1; #1;
            check(rd_data == GW'(i), "R1 store2 identity", int'(rd_data), i);
        end

        // Classic interior window.
        a1 = '{0, 1, 2, 3, 4, 5, 6, 7};
        a2 = '{3, 7, 5, 1, 6, 0, 2, 4};
        run_case(3, 5, 1'b0);
        // R6: no top part.
        a1 = '{5, 2, 7, 0, 3, 6, 1, 4};
        a2 = '{1, 6, 0, 4, 7, 2, 5, 3};
        run_case(0, 4, 1'b0);
        // R6: no bottom part.
        run_case(2, 7, 1'b0);
        // R6: window covers the whole tour, both parts skipped.
        run_case(0, 7, 1'b0);
        // R6: single-gene window.
        a1 = '{7, 6, 5, 4, 3, 2, 1, 0};
        a2 = '{2, 0, 4, 6, 1, 3, 7, 5};
        run_case(4, 4, 1'b0);
        // R5: long remap chain.
        a1 = '{0, 1, 2, 3, 4, 5, 6, 7};
        a2 = '{1, 2, 3, 4, 5, 6, 7, 0};
        run_case(1, 6, 1'b0);
        // R9: write and start while busy are ignored.
        a1 = '{4, 0, 6, 2, 7, 1, 3, 5};
        a2 = '{6, 3, 1, 7, 0, 5, 4, 2};
        run_case(2, 4, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule